// File: doc/BRIEF.md
# Windowed Memory Address Translator

This block turns a processor's logical addresses into physical memory targets. Data addresses are 16 bits wide. The lower half of the data space and the upper quarter go straight to on-chip data RAM. The third quarter is a 16 KB window. One data map register decides whether that window points into on-chip instruction RAM or into one 16 KB slice of a large unified memory. The unified memory is split into 128 KB segments.

Instruction byte addresses are 18 bits wide. The top address bit chooses between two instruction map registers. The chosen map either passes the address straight to instruction RAM or redirects it into a unified-memory segment.

Translation is purely combinational, so the result follows the address inputs in the same cycle. The three map registers are loaded through a small write port, and a write affects translation from the next clock edge on. A parameter mask marks which unified segments are populated. Any access to a missing segment, or to a segment number beyond the populated range, raises a bus-error flag. A small legal register range near the top of the data space also raises the flag when any other address in the upper quarter is used.

Top module: `amap_xlate`

## Requirements
- R1: After reset, both instruction maps hold 0x1000 and the data map holds 0x0000. Instruction addresses therefore reach instruction RAM unchanged, and the data window reaches unified segment 0 at offset 0.
- R2: A data address below 0x8000 gives target code 0 (data RAM) and a physical address equal to the logical address, with no error. The target codes are: 0 = data RAM, 1 = instruction RAM, 2 = unified memory.
- R3: A data address of 0xC000 or above gives target 0 and a physical address equal to the logical address. The error flag is low only for 0xFF00 through 0xFF0F.
- R4: A data address in 0x8000–0xBFFF, with data-map bit 12 set, gives target 1. The physical address is data-map bits 3:0 × 0x4000 plus the address minus 0x8000.
- R5: A data address in 0x8000–0xBFFF, with data-map bit 12 clear, gives target 2. The segment is data-map bits 9:3 and the offset is data-map bits 2:0 × 0x4000 plus the address minus 0x8000. The physical address is the segment in bits 23:17 and the offset in bits 16:0.
- R6: Instruction address bit 17 selects the second instruction map when set, and the first when clear.
- R7: When the selected instruction map has bit 12 set, the result is target 1 with the physical address equal to the full 18-bit instruction address, and no error.
- R8: When the selected instruction map has bit 12 clear, the result is target 2. The segment is map bits 7:0 and the offset is the low 17 address bits. The physical address carries the low 7 segment bits in bits 23:17.
- R9: A unified access raises the error flag when its segment number is at or above the segment count, or when its bit in the presence mask is clear.
- R10: A write strobe with select 0, 1 or 2 loads the data map, the first instruction map or the second instruction map, at the next rising edge. Select 3, or a strobe held low, changes no map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Map write strobe |
| cfg_sel | input | 2 | Map select: 0 data, 1 first instruction, 2 second instruction |
| cfg_wdata | input | 16 | Value to load into the selected map |
| d_addr | input | 16 | Logical data address |
| d_tgt | output | 2 | Data target code |
| d_phys | output | 24 | Data physical address |
| d_err | output | 1 | Data bus error |
| i_addr | input | 18 | Logical instruction byte address |
| i_tgt | output | 2 | Instruction target code |
| i_phys | output | 24 | Instruction physical address |
| i_err | output | 1 | Instruction bus error |

## Verification
The assertions sample the combinational outputs at each rising edge. They assume the address inputs have settled before that edge and are defined whenever reset is released. The register assertions assume the select and strobe are stable across the edge that captures them. The bench holds all inputs at zero through reset and changes addresses and the write port only at falling edges. It also uses the unused select code 3, so the hold rule is exercised as well as the load rule.

// File: rtl/amap_pkg.sv
package amap_pkg;
  typedef enum logic [1:0] {
    TGT_DRAM = 2'd0,
    TGT_IRAM = 2'd1,
    TGT_UMEM = 2'd2
  } tgt_e;

  localparam int MAP_W     = 16;
  localparam int DADDR_W   = 16;
  localparam int IADDR_W   = 18;
  localparam int SEG_OFF_W = 17;
  localparam int WIN_OFF_W = 14;
  localparam int SEG_IDX_W = 7;
  localparam int SEGN_W    = 8;
  localparam int PHYS_W    = SEG_IDX_W + SEG_OFF_W;
  localparam int SEL_W     = 2;
  localparam int NUM_MAPS  = 3;

  localparam int MAP_IRAM_BIT = 12;
  localparam int IBANK_BIT    = IADDR_W - 1;

  localparam logic [SEL_W-1:0] SEL_DMAP  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_IMAP0 = 2'd1;
  localparam logic [SEL_W-1:0] SEL_IMAP1 = 2'd2;

  localparam logic [MAP_W-1:0] DMAP_RST = 16'h0000;
  localparam logic [MAP_W-1:0] IMAP_RST = 16'h1000;

  localparam logic [11:0] IO_PAGE = 12'hFF0;
endpackage

// File: rtl/amap_seg_check.sv
module amap_seg_check
  import amap_pkg::*;
#(
  parameter int                  NUM_SEGS    = 128,
  parameter logic [NUM_SEGS-1:0] SEG_PRESENT = '1
) (
  input  logic [SEGN_W-1:0] seg_num,
  output logic              seg_ok
);
  always_comb begin
    seg_ok = 1'b0;
    for (int s = 0; s < NUM_SEGS; s++) begin
      if (seg_num == SEGN_W'(s)) seg_ok = SEG_PRESENT[s];
    end
  end
endmodule

// File: rtl/amap_regs.sv
module amap_regs
  import amap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [MAP_W-1:0] cfg_wdata,
  output logic [MAP_W-1:0] dmap,
  output logic [MAP_W-1:0] imap0,
  output logic [MAP_W-1:0] imap1
);
  function automatic logic [MAP_W-1:0] map_reset(int idx);
    return (idx == 0) ? DMAP_RST : IMAP_RST;
  endfunction

  logic [MAP_W-1:0] map_q [NUM_MAPS];

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        map_q[g] <= map_reset(g);
      else if (cfg_we && cfg_sel == SEL_W'(g))
        map_q[g] <= cfg_wdata;
    end
  end

  assign dmap  = map_q[0];
  assign imap0 = map_q[1];
  assign imap1 = map_q[2];

  // R10: a selected write lands on the next edge
  p_dmap_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_DMAP) |=> (dmap == $past(cfg_wdata)));

  // R10: instruction map 0 untouched unless addressed
  p_imap0_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_sel == SEL_IMAP0) |=> $stable(imap0));

  // R10: unused select leaves every map alone
  p_sel3_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |=> ($stable(dmap) && $stable(imap0) && $stable(imap1)));
endmodule

// File: rtl/amap_dxlate.sv
module amap_dxlate
  import amap_pkg::*;
#(
  parameter int                  NUM_SEGS    = 128,
  parameter logic [NUM_SEGS-1:0] SEG_PRESENT = '1
) (
  input  logic [DADDR_W-1:0] d_addr,
  input  logic [MAP_W-1:0]   dmap,
  output tgt_e               tgt,
  output logic [PHYS_W-1:0]  phys,
  output logic               err
);
  logic                 in_high, in_win, seg_ok;
  logic [SEG_IDX_W-1:0] win_seg;
  logic [2:0]           win_slice;
  logic [3:0]           iram_slice;
  logic                 unused_map;

  assign in_high    = (d_addr[DADDR_W-1 -: 2] == 2'b11);
  assign in_win     = (d_addr[DADDR_W-1 -: 2] == 2'b10);
  assign win_seg    = dmap[9:3];
  assign win_slice  = dmap[2:0];
  assign iram_slice = dmap[3:0];
  assign unused_map = ^{dmap[MAP_W-1:MAP_IRAM_BIT+1], dmap[MAP_IRAM_BIT-1:10]};

  amap_seg_check #(.NUM_SEGS(NUM_SEGS), .SEG_PRESENT(SEG_PRESENT)) u_seg (
    .seg_num ({1'b0, win_seg}),
    .seg_ok  (seg_ok)
  );

  always_comb begin
    tgt  = TGT_DRAM;
    phys = PHYS_W'(d_addr);
    err  = 1'b0;
    if (in_high) begin
      err = (d_addr[DADDR_W-1:4] != IO_PAGE);
    end else if (in_win) begin
      if (dmap[MAP_IRAM_BIT]) begin
        tgt  = TGT_IRAM;
        phys = PHYS_W'({iram_slice, d_addr[WIN_OFF_W-1:0]});
      end else begin
        tgt  = TGT_UMEM;
        phys = {win_seg, win_slice, d_addr[WIN_OFF_W-1:0]};
        err  = !seg_ok;
      end
    end
  end
endmodule

// File: rtl/amap_ixlate.sv
module amap_ixlate
  import amap_pkg::*;
#(
  parameter int                  NUM_SEGS    = 128,
  parameter logic [NUM_SEGS-1:0] SEG_PRESENT = '1
) (
  input  logic [IADDR_W-1:0] i_addr,
  input  logic [MAP_W-1:0]   imap0,
  input  logic [MAP_W-1:0]   imap1,
  output tgt_e               tgt,
  output logic [PHYS_W-1:0]  phys,
  output logic               err
);
  logic [MAP_W-1:0] sel_map;
  logic             seg_ok;
  logic             unused_map;

  assign sel_map    = i_addr[IBANK_BIT] ? imap1 : imap0;
  assign unused_map = ^{sel_map[MAP_W-1:MAP_IRAM_BIT+1], sel_map[MAP_IRAM_BIT-1:SEGN_W]};

  amap_seg_check #(.NUM_SEGS(NUM_SEGS), .SEG_PRESENT(SEG_PRESENT)) u_seg (
    .seg_num (sel_map[SEGN_W-1:0]),
    .seg_ok  (seg_ok)
  );

  always_comb begin
    if (sel_map[MAP_IRAM_BIT]) begin
      tgt  = TGT_IRAM;
      phys = PHYS_W'(i_addr);
      err  = 1'b0;
    end else begin
      tgt  = TGT_UMEM;
      phys = {sel_map[SEG_IDX_W-1:0], i_addr[SEG_OFF_W-1:0]};
      err  = !seg_ok;
    end
  end
endmodule

// File: rtl/amap_xlate.sv
module amap_xlate
  import amap_pkg::*;
#(
  parameter int                  NUM_SEGS    = 128,
  parameter logic [NUM_SEGS-1:0] SEG_PRESENT = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [MAP_W-1:0]    cfg_wdata,
  input  logic [DADDR_W-1:0]  d_addr,
  output logic [1:0]          d_tgt,
  output logic [PHYS_W-1:0]   d_phys,
  output logic                d_err,
  input  logic [IADDR_W-1:0]  i_addr,
  output logic [1:0]          i_tgt,
  output logic [PHYS_W-1:0]   i_phys,
  output logic                i_err
);
  logic [MAP_W-1:0] dmap, imap0, imap1;
  tgt_e             d_tgt_e, i_tgt_e;

  amap_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .dmap      (dmap),
    .imap0     (imap0),
    .imap1     (imap1)
  );

  amap_dxlate #(.NUM_SEGS(NUM_SEGS), .SEG_PRESENT(SEG_PRESENT)) u_dx (
    .d_addr (d_addr),
    .dmap   (dmap),
    .tgt    (d_tgt_e),
    .phys   (d_phys),
    .err    (d_err)
  );

  amap_ixlate #(.NUM_SEGS(NUM_SEGS), .SEG_PRESENT(SEG_PRESENT)) u_ix (
    .i_addr (i_addr),
    .imap0  (imap0),
    .imap1  (imap1),
    .tgt    (i_tgt_e),
    .phys   (i_phys),
    .err    (i_err)
  );

  assign d_tgt = d_tgt_e;
  assign i_tgt = i_tgt_e;

  // R2: low half of the data space is an identity map
  p_dlow_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (d_addr < 16'h8000) |-> (d_tgt == 2'd0 && d_phys == PHYS_W'(d_addr) && !d_err));

  // R3: legal register page never errs
  p_io_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_addr[DADDR_W-1:4] == IO_PAGE) |-> (!d_err && d_tgt == 2'd0));

  // R3: rest of the upper quarter always errs
  p_io_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_addr >= 16'hC000 && d_addr[DADDR_W-1:4] != IO_PAGE) |-> d_err);

  // R4: instruction-RAM window keeps the in-window offset and is clean
  p_dwin_iram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_tgt == 2'd1) |-> (d_phys[WIN_OFF_W-1:0] == d_addr[WIN_OFF_W-1:0] && !d_err
                         && d_phys[PHYS_W-1:18] == '0));

  // R7: direct instruction fetches never err
  p_iram_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_tgt == 2'd1) |-> (!i_err && i_phys == PHYS_W'(i_addr)));

  // R8: unified fetch keeps the low 17 address bits
  p_iumem_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (i_tgt == 2'd2) |-> (i_phys[SEG_OFF_W-1:0] == i_addr[SEG_OFF_W-1:0]));
endmodule

// File: tb/amap_xlate_test.sv
`timescale 1ns/1ps
module amap_xlate_test;
  localparam int NSEG = 128;
  localparam logic [NSEG-1:0] MASK = ~(128'd1 << 5);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] d_addr = 16'h0;
  logic [17:0] i_addr = 18'h0;
  logic [1:0]  d_tgt, i_tgt;
  logic [23:0] d_phys, i_phys;
  logic        d_err, i_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  amap_xlate #(.NUM_SEGS(NSEG), .SEG_PRESENT(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .d_addr(d_addr), .d_tgt(d_tgt), .d_phys(d_phys), .d_err(d_err),
    .i_addr(i_addr), .i_tgt(i_tgt), .i_phys(i_phys), .i_err(i_err)
  );

  // {req, dmap, addr, tgt, phys, err}
  localparam int ND = 13;
  localparam logic [62:0] DVEC [ND] = '{
    {4'd2, 16'h0000, 16'h0000, 2'd0, 24'h000000, 1'b0},  // R2
    {4'd2, 16'h0000, 16'h7FFF, 2'd0, 24'h007FFF, 1'b0},  // R2
    {4'd3, 16'h0000, 16'hFF00, 2'd0, 24'h00FF00, 1'b0},  // R3
    {4'd3, 16'h0000, 16'hFF0F, 2'd0, 24'h00FF0F, 1'b0},  // R3
    {4'd3, 16'h0000, 16'hFF10, 2'd0, 24'h00FF10, 1'b1},  // R3
    {4'd3, 16'h0000, 16'hC000, 2'd0, 24'h00C000, 1'b1},  // R3
    {4'd3, 16'h0000, 16'hFEFF, 2'd0, 24'h00FEFF, 1'b1},  // R3
    {4'd4, 16'h1003, 16'h8000, 2'd1, 24'h00C000, 1'b0},  // R4
    {4'd4, 16'h100F, 16'hBFFF, 2'd1, 24'h03FFFF, 1'b0},  // R4
    {4'd5, 16'h0000, 16'h8004, 2'd2, 24'h000004, 1'b0},  // R5
    {4'd5, 16'h03FF, 16'h9234, 2'd2, 24'hFFD234, 1'b0},  // R5
    {4'd5, 16'h0419, 16'hA000, 2'd2, 24'h066000, 1'b0},  // R5
    {4'd9, 16'h002A, 16'h8010, 2'd2, 24'h0A8010, 1'b1}   // R9 segment 5 absent
  };

  // {req, imap0, imap1, iaddr, tgt, phys, err}
  localparam int NI = 9;
  localparam logic [80:0] IVEC [NI] = '{
    {4'd7, 16'h1000, 16'h1000, 18'h00000, 2'd1, 24'h000000, 1'b0},  // R7
    {4'd7, 16'h1000, 16'h1000, 18'h3FFFC, 2'd1, 24'h03FFFC, 1'b0},  // R7
    {4'd8, 16'h0002, 16'h1000, 18'h01234, 2'd2, 24'h041234, 1'b0},  // R8
    {4'd6, 16'h0002, 16'h1000, 18'h21234, 2'd1, 24'h021234, 1'b0},  // R6
    {4'd8, 16'h1000, 16'h0040, 18'h3ABCD, 2'd2, 24'h81ABCD, 1'b0},  // R8 truncation
    {4'd6, 16'h1000, 16'h0040, 18'h1ABCD, 2'd1, 24'h01ABCD, 1'b0},  // R6
    {4'd9, 16'h0080, 16'h1000, 18'h00010, 2'd2, 24'h000010, 1'b1},  // R9 out of range
    {4'd9, 16'h0005, 16'h1000, 18'h00020, 2'd2, 24'h0A0020, 1'b1},  // R9 absent
    {4'd7, 16'h10FF, 16'h1000, 18'h00100, 2'd1, 24'h000100, 1'b0}   // R7
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic write_map(logic [1:0] sel, logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_d(string req, logic [15:0] a, logic [1:0] t, logic [23:0] p, logic e);
    d_addr = a;
    #1;
    chk(req, "d_tgt", 32'(d_tgt), 32'(t));
    chk(req, "d_phys", 32'(d_phys), 32'(p));
    chk(req, "d_err", 32'(d_err), 32'(e));
  endtask

  task automatic check_i(string req, logic [17:0] a, logic [1:0] t, logic [23:0] p, logic e);
    i_addr = a;
    #1;
    chk(req, "i_tgt", 32'(i_tgt), 32'(t));
    chk(req, "i_phys", 32'(i_phys), 32'(p));
    chk(req, "i_err", 32'(i_err), 32'(e));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values of the maps
    check_d("R1", 16'h8000, 2'd2, 24'h000000, 1'b0);
    check_i("R1", 18'h00040, 2'd1, 24'h000040, 1'b0);
    check_i("R1", 18'h20040, 2'd1, 24'h020040, 1'b0);

    // R10: load, ignored select, idle strobe
    write_map(2'd0, 16'h1001);
    check_d("R10", 16'h8000, 2'd1, 24'h004000, 1'b0);
    write_map(2'd3, 16'h0000);
    check_d("R10", 16'h8000, 2'd1, 24'h004000, 1'b0);
    check_i("R10", 18'h00010, 2'd1, 24'h000010, 1'b0);
    @(negedge clk);
    cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 16'h0000;
    @(negedge clk);
    check_d("R10", 16'h8000, 2'd1, 24'h004000, 1'b0);
    write_map(2'd1, 16'h0003);
    check_i("R10", 18'h00010, 2'd2, 24'h060010, 1'b0);
    check_i("R10", 18'h20010, 2'd1, 24'h020010, 1'b0);
    write_map(2'd2, 16'h0001);
    check_i("R10", 18'h20010, 2'd2, 24'h020010, 1'b0);

    for (int k = 0; k < ND; k++) begin
      logic [62:0] v;
      v = DVEC[k];
      write_map(2'd0, v[58:43]);
      check_d($sformatf("R%0d", v[62:59]), v[42:27], v[26:25], v[24:1], v[0]);
    end

    for (int k = 0; k < NI; k++) begin
      logic [80:0] v;
      v = IVEC[k];
      write_map(2'd1, v[76:61]);
      write_map(2'd2, v[60:45]);
      check_i($sformatf("R%0d", v[80:77]), v[44:27], v[26:25], v[24:1], v[0]);
    end

    // R1: reset in mid run restores all maps
    write_map(2'd0, 16'h1005);
    write_map(2'd2, 16'h0007);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_d("R1", 16'h8000, 2'd2, 24'h000000, 1'b0);
    check_i("R1", 18'h20040, 2'd1, 24'h020040, 1'b0);
    check_i("R1", 18'h00040, 2'd1, 24'h000040, 1'b0);

    done = 1;
    summary();
    $finish;
  end
endmodule